// File: doc/BRIEF.md
# Expansion ROM Window Decoder

This block holds the base-address register of a bus agent's expansion ROM and decodes the memory window that the register describes. A boot-time mask, read from external non-volatile storage, sets two things. It sets which base-address bits the host may program, and so the window size the host can discover. It also sets whether the host may flip the decode-enable bit. Host configuration accesses read and write the register at one fixed configuration offset.

When the register's enable bit and the command register's memory-space enable are both set, a memory read whose upper address bits match the programmed base is claimed. The read is served by fetching the requested bytes one at a time from a narrow ROM over a request/acknowledge port, using an 11-bit byte address. The bytes are packed into a 32-bit word, and the bus is held waiting until the word is complete. Writes that hit the window are claimed and finished at once, and the ROM is never touched for them.

Top module: `romwin_decoder`

## Requirements
- R1: After reset the register reads 00000000h. A configuration read returns the register only when cfg_addr[7:2] equals 30h>>2; every other offset reads 0.
- R2: Register bits 10:1 always read as zero, whatever is written.
- R3: A base bit n (31..11) takes the written value only when boot mask bit n is 1, and reads 0 otherwise. Writing FFFFFFFFh and reading back therefore shows the window size through the low-order zeros.
- R4: Register bit 0 (decode enable) changes on a host write only when boot mask bit 0 is 1; otherwise it keeps its value.
- R5: A boot load (boot_load high for one cycle, mask on boot_mask) replaces the mask, and it clears any base bit that the new mask no longer permits. The enable bit is kept.
- R6: bus_hit is 1 only when all of these hold: enable bit set, mem_space_en set, at least one base bit writable, and (bus_addr[31:11] XOR base) AND mask equal to zero.
- R7: A read hit with byte enables bus_be (bit k = lane k, active high) fetches exactly the enabled lanes, in ascending lane order. The ROM address is {bus_addr[10:2], lane}.
- R8: The fetched byte for lane k lands in bus_rdata[8k+7:8k], and disabled lanes read 0. bus_wait is high while bytes are outstanding. bus_done pulses for one cycle, the cycle after the last acknowledge, with bus_rdata valid.
- R9: A write hit raises bus_done in the following cycle with no ROM request.
- R10: A read hit with bus_be = 0 raises bus_done in the following cycle with bus_rdata = 0 and no ROM request.
- R11: While rom_req is high without rom_ack, rom_req and rom_addr hold steady into the next cycle.
- R12: A request that does not hit produces neither bus_done nor a ROM request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_load | input | 1 | One-cycle strobe that loads boot_mask |
| boot_mask | input | 32 | Writable-bit mask from non-volatile storage |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| mem_space_en | input | 1 | Command register memory-space enable |
| bus_req | input | 1 | Bus request, held until bus_done |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Bus byte address |
| bus_be | input | 4 | Byte-lane enables, active high |
| bus_hit | output | 1 | Address falls in the enabled window |
| bus_wait | output | 1 | Fetch in progress |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Assembled read word |
| rom_req | output | 1 | ROM byte request |
| rom_addr | output | 11 | ROM byte address |
| rom_ack | input | 1 | ROM byte acknowledge |
| rom_data | input | 8 | ROM byte, valid with rom_ack |

## Verification
The case hardest to reach from the ports is a sparse byte-enable pattern on a read hit while the ROM answers with varying latency. This is the case that checks the lane order, the address hold under back-pressure and the zeroing of skipped lanes. The bench ROM model picks a fresh latency of zero to two cycles for every byte and logs each acknowledged address. Directed reads with patterns such as 0101b, 1000b and 0000b are followed by seeded random operations mixing hits, misses, writes and random enables. A boot mask with no writable address bit exercises the empty-window rule.

// File: rtl/romwin_pkg.sv
package romwin_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ROM_AW = 11;
  localparam int unsigned LANES  = BUS_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  // lowest enabled lane, ascending fetch order
  function automatic logic [LANE_W-1:0] first_lane(input logic [LANES-1:0] m);
    logic [LANE_W-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (m[i]) r = LANE_W'(i);
    end
    return r;
  endfunction

  // upper-address compare under the writable mask
  function automatic logic window_match(input logic [BUS_W-1:0] addr,
                                        input logic [BUS_W-1:ROM_AW] base,
                                        input logic [BUS_W-1:ROM_AW] wmask);
    return ((addr[BUS_W-1:ROM_AW] ^ base) & wmask) == '0;
  endfunction

  // little-endian byte placement
  function automatic logic [BUS_W-1:0] place_byte(input logic [BUS_W-1:0] word,
                                                  input logic [LANE_W-1:0] lane,
                                                  input logic [7:0] b);
    logic [BUS_W-1:0] r;
    r = word;
    r[lane*8 +: 8] = b;
    return r;
  endfunction

  function automatic logic [LANES-1:0] drop_lane(input logic [LANES-1:0] m,
                                                 input logic [LANE_W-1:0] lane);
    logic [LANES-1:0] r;
    r = m;
    r[lane] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/romwin_cfg_reg.sv
module romwin_cfg_reg
  import romwin_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    boot_load,
  input  logic [BUS_W-1:0]        boot_mask,
  input  logic                    wr_en,
  input  logic [BUS_W-1:0]        wdata,
  output logic [BUS_W-1:ROM_AW]   base_q,
  output logic                    en_q,
  output logic [BUS_W-1:ROM_AW]   wmask_q,
  output logic                    en_perm_q,
  output logic [BUS_W-1:0]        reg_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      en_q      <= 1'b0;
      wmask_q   <= '0;
      en_perm_q <= 1'b0;
    end else if (boot_load) begin
      wmask_q   <= boot_mask[BUS_W-1:ROM_AW];
      en_perm_q <= boot_mask[0];
      base_q    <= base_q & boot_mask[BUS_W-1:ROM_AW];
    end else if (wr_en) begin
      base_q <= wdata[BUS_W-1:ROM_AW] & wmask_q;
      if (en_perm_q) en_q <= wdata[0];
    end
  end

  assign reg_word = {base_q, {(ROM_AW-1){1'b0}}, en_q};
endmodule

// File: rtl/romwin_decode.sv
module romwin_decode
  import romwin_pkg::*;
(
  input  logic [BUS_W-1:0]        addr,
  input  logic [BUS_W-1:ROM_AW]   base,
  input  logic [BUS_W-1:ROM_AW]   wmask,
  input  logic                    en,
  input  logic                    mem_space_en,
  output logic                    hit
);
  logic sized;
  assign sized = |wmask;
  assign hit   = en && mem_space_en && sized && window_match(addr, base, wmask);
endmodule

// File: rtl/romwin_fetch.sv
module romwin_fetch
  import romwin_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_rd,
  input  logic                    start_wr,
  input  logic [ROM_AW-1:LANE_W]  start_word,
  input  logic [LANES-1:0]        start_be,
  input  logic                    rom_ack,
  input  logic [7:0]              rom_data,
  output logic                    rom_req,
  output logic [ROM_AW-1:0]       rom_addr,
  output logic                    busy,
  output logic                    done,
  output logic [BUS_W-1:0]        rdata
);
  logic [LANES-1:0]         left_q;
  logic [ROM_AW-1:LANE_W]   word_q;
  logic [BUS_W-1:0]         data_q;
  logic                     busy_q, done_q;
  logic [LANE_W-1:0]        lane;
  logic                     last_ack;

  assign lane     = first_lane(left_q);
  assign last_ack = busy_q && rom_ack && (drop_lane(left_q, lane) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      word_q <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_wr || (start_rd && start_be == '0)) begin
        data_q <= '0;
        done_q <= 1'b1;
      end else if (start_rd) begin
        data_q <= '0;
        left_q <= start_be;
        word_q <= start_word;
        busy_q <= 1'b1;
      end else if (busy_q && rom_ack) begin
        data_q <= place_byte(data_q, lane, rom_data);
        left_q <= drop_lane(left_q, lane);
        if (last_ack) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rom_req  = busy_q;
  assign rom_addr = {word_q, lane};
  assign busy     = busy_q;
  assign done     = done_q;
  assign rdata    = data_q;
endmodule

// File: rtl/romwin_decoder.sv
module romwin_decoder
  import romwin_pkg::*;
#(
  parameter logic [7:0] CFG_OFFSET = 8'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_load,
  input  logic [BUS_W-1:0]   boot_mask,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [7:0]         cfg_addr,
  input  logic [BUS_W-1:0]   cfg_wdata,
  output logic [BUS_W-1:0]   cfg_rdata,
  input  logic               mem_space_en,
  input  logic               bus_req,
  input  logic               bus_write,
  input  logic [BUS_W-1:0]   bus_addr,
  input  logic [LANES-1:0]   bus_be,
  output logic               bus_hit,
  output logic               bus_wait,
  output logic               bus_done,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               rom_req,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic               rom_ack,
  input  logic [7:0]         rom_data
);
  logic                    cfg_sel;
  logic [BUS_W-1:ROM_AW]   base_q, wmask_q;
  logic                    en_q, en_perm_q;
  logic [BUS_W-1:0]        reg_word;
  logic                    busy, done;
  logic                    accept, accept_rd, accept_wr;

  assign cfg_sel = cfg_addr[7:2] == CFG_OFFSET[7:2];

  romwin_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load), .boot_mask(boot_mask),
    .wr_en(cfg_wr && cfg_sel), .wdata(cfg_wdata),
    .base_q(base_q), .en_q(en_q), .wmask_q(wmask_q), .en_perm_q(en_perm_q),
    .reg_word(reg_word)
  );

  romwin_decode u_dec (
    .addr(bus_addr), .base(base_q), .wmask(wmask_q), .en(en_q),
    .mem_space_en(mem_space_en), .hit(bus_hit)
  );

  assign accept    = bus_req && bus_hit && !busy && !done;
  assign accept_rd = accept && !bus_write;
  assign accept_wr = accept && bus_write;

  romwin_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .start_rd(accept_rd), .start_wr(accept_wr),
    .start_word(bus_addr[ROM_AW-1:LANE_W]), .start_be(bus_be),
    .rom_ack(rom_ack), .rom_data(rom_data), .rom_req(rom_req), .rom_addr(rom_addr),
    .busy(busy), .done(done), .rdata(bus_rdata)
  );

  assign cfg_rdata = (cfg_rd && cfg_sel) ? reg_word : '0;
  assign bus_wait  = busy;
  assign bus_done  = done;
endmodule

// File: rtl/romwin_checker.sv
module romwin_checker
  import romwin_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_rd,
  input logic                  cfg_wr,
  input logic                  cfg_sel,
  input logic                  boot_load,
  input logic [BUS_W-1:0]      cfg_rdata,
  input logic                  en_q,
  input logic                  en_perm_q,
  input logic                  bus_hit,
  input logic                  mem_space_en,
  input logic                  bus_req,
  input logic                  accept_wr,
  input logic                  busy,
  input logic                  done,
  input logic                  rom_req,
  input logic                  rom_ack,
  input logic [ROM_AW-1:0]     rom_addr
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_sel) |-> cfg_rdata[ROM_AW-1:1] == '0);

  p_enable_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && !en_perm_q && !boot_load) |=> $stable(en_q));

  p_hit_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> (en_q && mem_space_en));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_write_no_rom_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |=> (done && !rom_req));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_ack) |=> (rom_req && $stable(rom_addr)));

  p_miss_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_hit && !busy && !done) |=> (!rom_req && !done));
endmodule

bind romwin_decoder romwin_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .boot_load(boot_load), .cfg_rdata(cfg_rdata), .en_q(en_q), .en_perm_q(en_perm_q),
  .bus_hit(bus_hit), .mem_space_en(mem_space_en), .bus_req(bus_req),
  .accept_wr(accept_wr), .busy(busy), .done(done), .rom_req(rom_req),
  .rom_ack(rom_ack), .rom_addr(rom_addr)
);

// File: tb/romwin_decoder_bench.sv
module romwin_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_load = 0; logic [31:0] boot_mask = '0;
  logic cfg_wr = 0, cfg_rd = 0; logic [7:0] cfg_addr = '0; logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic mem_space_en = 0;
  logic bus_req = 0, bus_write = 0; logic [31:0] bus_addr = '0; logic [3:0] bus_be = '0;
  logic bus_hit, bus_wait, bus_done; logic [31:0] bus_rdata;
  logic rom_req; logic [10:0] rom_addr; logic rom_ack = 0; logic [7:0] rom_data = '0;

  int vectors = 0, miscompares = 0;
  int ack_total = 0;
  logic [10:0] ack_log [0:63];
  int lat_cnt = 0, lat_goal = 0;

  logic [31:0] m_base = '0, m_wmask = '0; logic m_en = 0, m_perm = 0;

  always #2.5 clk = ~clk;

  romwin_decoder u_romwin_decoder (.*);

  function automatic logic [7:0] rom_byte(input logic [10:0] a);
    return (a[7:0] * 8'd29) ^ {5'b0, a[10:8]} ^ 8'h5A;
  endfunction

  function automatic logic model_hit(input logic [31:0] a);
    return m_en && mem_space_en && (m_wmask != 0) && (((a ^ m_base) & m_wmask) == 0);
  endfunction

  // ROM model: fresh 0..2 cycle latency for each byte
  always @(negedge clk) begin
    if (rom_ack) begin
      rom_ack <= 1'b0; lat_cnt <= 0; lat_goal <= $urandom % 3;
    end else if (rom_req) begin
      if (lat_cnt >= lat_goal) begin
        rom_ack <= 1'b1; rom_data <= rom_byte(rom_addr);
        ack_log[ack_total % 64] = rom_addr; ack_total = ack_total + 1;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic boot(input logic [31:0] m);
    @(negedge clk); boot_load = 1; boot_mask = m;
    @(negedge clk); boot_load = 0;
    m_wmask = m & 32'hFFFF_F800; m_perm = m[0]; m_base = m_base & m_wmask;
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = 8'h30; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
    m_base = d & m_wmask; if (m_perm) m_en = d[0];
  endtask

  task automatic cfg_read(input string req, input logic [7:0] off);
    @(negedge clk); cfg_rd = 1; cfg_addr = off; #1;
    check(req, cfg_rdata, (off[7:2] == 6'h0C) ? (m_base | {31'b0, m_en}) : 32'h0);
    cfg_rd = 0;
  endtask

  task automatic bus_op(input string req, input logic wr, input logic [31:0] a, input logic [3:0] be);
    int start, seen, n;
    logic [31:0] exp;
    logic exp_hit;
    start = ack_total; seen = 0; exp = '0; n = 0;
    exp_hit = model_hit(a);
    @(negedge clk); bus_req = 1; bus_write = wr; bus_addr = a; bus_be = be; #1;
    check({req, " hit"}, {31'b0, bus_hit}, {31'b0, exp_hit});
    for (int c = 0; c < (exp_hit ? 60 : 6); c++) begin
      @(negedge clk);
      if (bus_done) begin seen = 1; break; end
    end
    if (!exp_hit) begin
      check({req, " miss no done"}, seen, 0);
      check({req, " miss no rom"}, ack_total - start, 0);
    end else begin
      check({req, " done"}, seen, 1);
      check({req, " wait clear at done"}, {31'b0, bus_wait}, 32'h0);
      if (wr || be == 0) begin
        check({req, " no rom"}, ack_total - start, 0);
        check({req, " data zero"}, bus_rdata, 32'h0);
      end else begin
        for (int k = 0; k < 4; k++) begin
          if (be[k]) begin
            exp[8*k +: 8] = rom_byte({a[10:2], 2'(k)});
            if (start + n < ack_total)
              check({req, " order"}, {21'b0, ack_log[(start + n) % 64]}, {21'b0, a[10:2], 2'(k)});
            n++;
          end
        end
        check({req, " fetch count"}, ack_total - start, n);
        check({req, " data"}, bus_rdata, exp);
      end
    end
    bus_req = 0; bus_write = 0;
    @(negedge clk);
    check({req, " done one cycle"}, {31'b0, bus_done}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cfg_read("R1 reset value", 8'h30);
    cfg_read("R1 other offset", 8'h34);
    boot(32'hFFFF_F801);
    cfg_write(32'hFFFF_FFFF);
    cfg_read("R2 R3 size probe 2K", 8'h30);
    boot(32'hFFFF_C001);
    cfg_read("R5 boot clears bits", 8'h30);
    cfg_write(32'hFFFF_FFFF);
    cfg_read("R3 size probe 16K", 8'h30);
    boot(32'hFFFF_F800);
    cfg_write(32'h0000_0000);
    cfg_read("R4 enable locked", 8'h30);
    boot(32'hFFFF_F801);
    cfg_write(32'h8000_0801);
    cfg_read("R3 base programmed", 8'h30);
    mem_space_en = 0;
    bus_op("R6 memory space off", 0, 32'h8000_0804, 4'hF);
    mem_space_en = 1;
    bus_op("R7 R8 full word", 0, 32'h8000_0A10, 4'hF);
    bus_op("R8 sparse 0101", 0, 32'h8000_0FFC, 4'b0101);
    bus_op("R7 lane 3 only", 0, 32'h8000_0800, 4'b1000);
    bus_op("R10 no lanes", 0, 32'h8000_0840, 4'b0000);
    bus_op("R9 write hit", 1, 32'h8000_0844, 4'hF);
    bus_op("R12 outside window", 0, 32'h8000_1000, 4'hF);
    cfg_write(32'h8000_0800);
    bus_op("R6 enable off", 0, 32'h8000_0804, 4'hF);
    boot(32'h0000_0001);
    cfg_write(32'h0000_0001);
    bus_op("R6 empty mask", 0, 32'h0000_0004, 4'hF);
    boot(32'hFFFF_F801);
    cfg_write(32'h4000_0001);
    for (int i = 0; i < 80; i++) begin
      logic [31:0] a;
      a = ($urandom % 3 != 0) ? (m_base | ($urandom & 32'h7FF)) : $urandom;
      if (i % 16 == 15) mem_space_en = ~mem_space_en;
      bus_op("R7 R8 R9 R12 random", ($urandom % 4) == 0, a, 4'($urandom));
    end
    cfg_read("R1 final readback", 8'h30);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule